// File: doc/BRIEF.md
# Pipeline Hazard Resolution Unit

This block holds the hazard decisions for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each cycle it compares the source register numbers of the instructions in decode and execute against the destination numbers and write-enable flags carried by the two later pipeline registers. From these comparisons it picks, for each ALU operand in execute, where the operand comes from: the register file read, the execute/memory register or the memory/write-back register. It also decides whether the front of the pipeline must freeze for one cycle behind a load, and whether the one fetched instruction behind a taken branch must be discarded.

All decisions are combinational and become visible in the cycle the inputs are presented. The surrounding pipeline uses `stall` to hold the PC and the fetch/decode register, `bubble` to zero the control fields loaded into the decode/execute register, and `flush` to clear the fetch/decode register. Branches resolve in decode and are predicted not taken, so fetch simply continues in sequence until a taken branch shows up. The register file writes early in the cycle and reads late in the cycle, so a decode read of a register being written back needs no help from this block. The clock and active-low reset are used only by the embedded property checks.

Top module: `hz_ctrl_unit`

## Requirements
- R1: Each operand select is a 2-bit code: 2'b00 takes the register file value, 2'b10 takes the execute/memory result and 2'b01 takes the write-back result. Operand A follows `ex_src_a` and operand B follows `ex_src_b`. The code 2'b11 never appears.
- R2: If `xm_wr_en` is high and `xm_dst` is nonzero and equals an execute source, that operand's select is 2'b10.
- R3: If `mw_wr_en` is high and `mw_dst` is nonzero and equals an execute source, and R2 does not apply to that operand, the select is 2'b01.
- R4: If both later stages match the same source, the execute/memory result wins and the select is 2'b10.
- R5: Register 0 never counts as a dependency, and neither does a stage whose write enable is low. Such a case gives select 2'b00 and no stall.
- R6: If `ex_is_load` is high, `ex_dst` is nonzero and `ex_dst` equals `id_src_a` or `id_src_b`, then `stall` and `bubble` are both high in that cycle. Otherwise both are low.
- R7: A non-load instruction in execute that writes a register read in decode causes no stall. That dependency is covered by forwarding.
- R8: A register being written in write-back and read in decode in the same cycle causes no stall.
- R9: If `id_br_taken` is high and there is no stall, `flush` is high. If `id_br_taken` is low, `flush` is low.
- R10: If a load-use stall and a taken branch occur in the same cycle, the stall wins: `stall` and `bubble` are high and `flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| id_src_a | input | REG_AW | First source register of the instruction in decode |
| id_src_b | input | REG_AW | Second source register of the instruction in decode |
| id_br_taken | input | 1 | Branch in decode is resolved as taken |
| ex_src_a | input | REG_AW | First source register of the instruction in execute |
| ex_src_b | input | REG_AW | Second source register of the instruction in execute |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| xm_dst | input | REG_AW | Destination held in the execute/memory register |
| xm_wr_en | input | 1 | Register-write flag in the execute/memory register |
| mw_dst | input | REG_AW | Destination held in the memory/write-back register |
| mw_wr_en | input | 1 | Register-write flag in the memory/write-back register |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Zero the control fields entering decode/execute |
| flush | output | 1 | Clear the fetch/decode register |

## Verification
Two decisions can fall in the same cycle and compete: the load-use interlock and the taken-branch flush. The bench provokes this by placing a load in execute whose destination matches a decode source while `id_br_taken` is high, both in directed cases and through random traffic restricted to a few register numbers. It checks that the stall wins with flush suppressed, because a branch resolved against a stale operand must not redirect fetch. A second collision, both later stages writing the same source, is provoked in the same way and judged against the priority rule.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF = 2'b00,
        FWD_WB = 2'b01,
        FWD_XM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic stall;
        logic bubble;
        logic flush;
    } hz_ctl_t;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] xm_dst,
    input  logic              xm_wr_en,
    input  logic [REG_AW-1:0] mw_dst,
    input  logic              mw_wr_en,
    output fwd_sel_e          sel_d
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic hit_xm;
    logic hit_wb;

    always_comb begin
        hit_xm = xm_wr_en && (xm_dst != ZERO_REG) && (xm_dst == src);
        hit_wb = mw_wr_en && (mw_dst != ZERO_REG) && (mw_dst == src);
        if (hit_xm) begin
            sel_d = FWD_XM;
        end else if (hit_wb) begin
            sel_d = FWD_WB;
        end else begin
            sel_d = FWD_RF;
        end
    end
endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]              ex_dst,
    input  logic                           ex_is_load,
    output logic                           hold_d
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] hit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign hit[s] = (id_src[s] == ex_dst);
    end

    always_comb begin
        hold_d = ex_is_load && (ex_dst != ZERO_REG) && (|hit);
    end
endmodule

// File: rtl/hz_branch_flush.sv
module hz_branch_flush (
    input  logic br_taken,
    input  logic hold,
    output logic flush_d
);
    always_comb begin
        flush_d = br_taken && !hold;
    end
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              id_br_taken,
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] xm_dst,
    input  logic              xm_wr_en,
    input  logic [REG_AW-1:0] mw_dst,
    input  logic              mw_wr_en,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              stall,
    output logic              bubble,
    output logic              flush
);
    localparam int NUM_SRC = 2;
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
    logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
    fwd_sel_e [NUM_SRC-1:0]          sel_d;
    logic                            hold_d;
    logic                            flush_d;
    hz_ctl_t                         ctl_d;

    assign ex_src = {ex_src_b, ex_src_a};
    assign id_src = {id_src_b, id_src_a};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
        hz_fwd_pick #(.REG_AW(REG_AW)) i_pick (
            .src      (ex_src[s]),
            .xm_dst   (xm_dst),
            .xm_wr_en (xm_wr_en),
            .mw_dst   (mw_dst),
            .mw_wr_en (mw_wr_en),
            .sel_d    (sel_d[s])
        );
    end

    hz_load_interlock #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) i_lock (
        .id_src     (id_src),
        .ex_dst     (ex_dst),
        .ex_is_load (ex_is_load),
        .hold_d     (hold_d)
    );

    hz_branch_flush i_flush (
        .br_taken (id_br_taken),
        .hold     (hold_d),
        .flush_d  (flush_d)
    );

    always_comb begin
        ctl_d        = '0;
        ctl_d.stall  = hold_d;
        ctl_d.bubble = hold_d;
        ctl_d.flush  = flush_d;
    end

    assign fwd_a  = sel_d[0];
    assign fwd_b  = sel_d[1];
    assign stall  = ctl_d.stall;
    assign bubble = ctl_d.bubble;
    assign flush  = ctl_d.flush;

    // Each select carries one of the three defined codes (R1)
    p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));

    // A write-back select means the nearer stage did not claim that operand (R4)
    p_wb_yields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == FWD_WB) |-> !(xm_wr_en && (xm_dst == ex_src_a)));

    // Register 0 never sources a forward (R5)
    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_b == ZERO_REG) |-> (fwd_b == FWD_RF));

    // A stall always comes with a bubble (R6)
    p_stall_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> bubble);

    // A stall only arises from a load in execute (R7)
    p_stall_needs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ex_is_load);

    // The stall suppresses the branch flush (R10)
    p_stall_over_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !flush);

    // A flush only arises from a taken branch (R9)
    p_flush_needs_br_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> id_br_taken);
endmodule

// File: tb/test_hz_ctrl_unit.sv
module test_hz_ctrl_unit;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_src_a = '0, id_src_b = '0;
    logic          id_br_taken = 1'b0;
    logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, ex_dst = '0;
    logic          ex_is_load = 1'b0;
    logic [AW-1:0] xm_dst = '0, mw_dst = '0;
    logic          xm_wr_en = 1'b0, mw_wr_en = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, bubble, flush;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hz_ctrl_unit #(.REG_AW(AW)) i_hz_ctrl_unit (.*);

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
        if (xm_wr_en && xm_dst != 0 && xm_dst == s) return 2'b10;
        if (mw_wr_en && mw_dst != 0 && mw_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall();
        return ex_is_load && ex_dst != 0 && (ex_dst == id_src_a || ex_dst == id_src_b);
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " fwd_a"}, fwd_a, exp_sel(ex_src_a));
        chk({req, " fwd_b"}, fwd_b, exp_sel(ex_src_b));
        chk({req, " stall"}, {1'b0, stall}, {1'b0, exp_stall()});
        chk({req, " bubble"}, {1'b0, bubble}, {1'b0, exp_stall()});
        chk({req, " flush"}, {1'b0, flush}, {1'b0, id_br_taken && !exp_stall()});
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_in();
        id_src_a = 0; id_src_b = 0; id_br_taken = 0;
        ex_src_a = 0; ex_src_b = 0; ex_dst = 0; ex_is_load = 0;
        xm_dst = 0; xm_wr_en = 0; mw_dst = 0; mw_wr_en = 0;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20071119));
        repeat (2) @(negedge clk);
        settle();
        chk("R1 reset fwd_a", fwd_a, 2'b00);
        chk("R1 reset fwd_b", fwd_b, 2'b00);
        chk("R6 reset stall", {1'b0, stall}, 2'b00);
        rst_n = 1'b1;

        // R2: execute/memory forward on operand A
        clear_in(); ex_src_a = 3; xm_dst = 3; xm_wr_en = 1; settle();
        chk("R2 fwd_a", fwd_a, 2'b10); chk("R2 fwd_b", fwd_b, 2'b00);
        // R3: write-back forward on operand B
        clear_in(); ex_src_b = 7; mw_dst = 7; mw_wr_en = 1; settle();
        chk("R3 fwd_b", fwd_b, 2'b01); chk("R3 fwd_a", fwd_a, 2'b00);
        // R4: both stages match, nearer wins
        clear_in(); ex_src_a = 5; ex_src_b = 5; xm_dst = 5; mw_dst = 5;
        xm_wr_en = 1; mw_wr_en = 1; settle();
        chk("R4 fwd_a", fwd_a, 2'b10); chk("R4 fwd_b", fwd_b, 2'b10);
        // R5: register 0 and disabled writes ignored
        clear_in(); xm_wr_en = 1; mw_wr_en = 1; ex_is_load = 1; settle();
        chk("R5 fwd_a r0", fwd_a, 2'b00);
        chk("R5 stall r0", {1'b0, stall}, 2'b00);
        clear_in(); ex_src_a = 9; xm_dst = 9; mw_dst = 9; settle();
        chk("R5 fwd_a no we", fwd_a, 2'b00);
        // R6: load-use on second decode source
        clear_in(); ex_is_load = 1; ex_dst = 4; id_src_b = 4; settle();
        chk("R6 stall", {1'b0, stall}, 2'b01); chk("R6 bubble", {1'b0, bubble}, 2'b01);
        // R7: non-load writer causes no stall
        ex_is_load = 0; settle();
        chk("R7 stall", {1'b0, stall}, 2'b00);
        // R8: write-back writer vs decode reader
        clear_in(); mw_dst = 6; mw_wr_en = 1; id_src_a = 6; settle();
        chk("R8 stall", {1'b0, stall}, 2'b00);
        // R9: taken branch flushes; untaken does not
        clear_in(); id_br_taken = 1; settle();
        chk("R9 flush", {1'b0, flush}, 2'b01);
        id_br_taken = 0; settle();
        chk("R9 no flush", {1'b0, flush}, 2'b00);
        // R10: stall and taken branch in the same cycle
        clear_in(); id_br_taken = 1; ex_is_load = 1; ex_dst = 2; id_src_a = 2; settle();
        chk("R10 stall", {1'b0, stall}, 2'b01);
        chk("R10 bubble", {1'b0, bubble}, 2'b01);
        chk("R10 flush", {1'b0, flush}, 2'b00);

        // Random traffic over a small register range to force collisions
        for (int i = 0; i < 3000; i++) begin
            id_src_a = AW'($urandom % 4); id_src_b = AW'($urandom % 4);
            ex_src_a = AW'($urandom % 4); ex_src_b = AW'($urandom % 4);
            ex_dst = AW'($urandom % 4); xm_dst = AW'($urandom % 4);
            mw_dst = AW'($urandom % 4);
            ex_is_load = 1'($urandom); xm_wr_en = 1'($urandom);
            mw_wr_en = 1'($urandom); id_br_taken = 1'($urandom);
            settle();
            check_all("R1-mix R2 R3 R4 R5 R6 R9 R10");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule